// File: doc/BRIEF.md
# Stream-Controlled Select Operator

This block is a dataflow operator that merges two data streams into one, with a boolean control stream deciding which source supplies each output token. It runs as a three-phase firing machine. In the control phase it waits for a control token and consumes it. It then moves to a data phase for the chosen source, waits for a token from that source, copies it into a single output register and returns to the control phase.

Every stream uses a valid/ready handshake, and every read blocks. A phase fires only once all inputs it depends on hold a token. A data phase also needs room in the output register. The block raises ready only on the streams the current phase reads. Tokens waiting on the stream that was not chosen are therefore never accepted, so none is lost. They stay upstream until a later control token selects that stream.

Top module: `strm_select`

## Requirements
- R1: After a synchronous reset the block is in the control phase with the output register empty: `out_valid`=0, `ctl_ready`=1, `tdat_ready`=0, `fdat_ready`=0.
- R2: In the control phase, `ctl_ready` is 1 and both data ready signals are 0, whatever the data valid inputs are.
- R3: A control token with value 1 moves the block to the true phase. The next output token is the next token of the true-data stream, and `fdat_ready` stays 0 until the block is back in the control phase, so a waiting false-data token is kept for later.
- R4: A control token with value 0 moves the block to the false phase. The next output token is the next token of the false-data stream, and `tdat_ready` stays 0.
- R5: In a data phase, `ctl_ready` is 0 and at most one of the three ready outputs is 1 at any time.
- R6: In a data phase with no token on the selected stream, the block holds its phase, consumes nothing and produces no output.
- R7: While `out_valid`=1 and `out_ready`=0, both data ready outputs are 0, so no data token is consumed.
- R8: A data phase may fire in the same cycle that the held output token is accepted (`out_ready`=1). With all inputs always valid and `out_ready` held at 1, the block delivers one token every two cycles.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid` stays 1 and `out_data` holds its value in the next cycle.
- R10: A data token accepted on a clock edge is on `out_data`, with `out_valid`=1, in the cycle right after that edge. The block then returns to the control phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ctl_valid | input | 1 | Control token present |
| ctl_ready | output | 1 | Control token accepted when valid |
| ctl_data | input | 1 | Control value: 1 selects true stream, 0 selects false stream |
| tdat_valid | input | 1 | True-data token present |
| tdat_ready | output | 1 | True-data token accepted when valid |
| tdat_data | input | 8 | True-data value (unsigned) |
| fdat_valid | input | 1 | False-data token present |
| fdat_ready | output | 1 | False-data token accepted when valid |
| fdat_data | input | 8 | False-data value (unsigned) |
| out_valid | output | 1 | Output token present |
| out_ready | input | 1 | Downstream accepts output token |
| out_data | output | 8 | Output token value |

## Verification
A wrong internal phase shows at the ports in the same cycle, because the ready outputs are decoded from the phase. The wrong stream is offered ready, or the control stream is offered ready during a data phase. A corrupted output register shows one cycle after the data firing, as a wrong or missing token on `out_data`. A wrong space computation shows as a data ready that is high under a stall, or low when the held token is being accepted. Each of these faults is checked in the cycle where it first becomes visible.

// File: rtl/strm_sel_pkg.sv
package strm_sel_pkg;

    localparam int SEL_DATA_W = 8;

    typedef enum logic [1:0] {
        PH_CTRL  = 2'd0,
        PH_TRUE  = 2'd1,
        PH_FALSE = 2'd2
    } phase_e;

    typedef struct packed {
        logic ctl;
        logic tru;
        logic fls;
    } fire_t;

    function automatic phase_e phase_after_ctrl(input logic sel_bit);
        return sel_bit ? PH_TRUE : PH_FALSE;
    endfunction

    function automatic logic out_has_space(input logic held, input logic taken);
        return !held || taken;
    endfunction

endpackage

// File: rtl/sel_fire_fsm.sv
module sel_fire_fsm
    import strm_sel_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   ctl_valid,
    input  logic   ctl_bit,
    input  logic   t_valid,
    input  logic   f_valid,
    input  logic   out_space,
    output logic   ctl_rdy,
    output logic   t_rdy,
    output logic   f_rdy,
    output fire_t  fire
);

    phase_e phase_q;
    phase_e phase_d;

    always_comb begin
        ctl_rdy = (phase_q == PH_CTRL);
        t_rdy   = (phase_q == PH_TRUE)  && out_space;
        f_rdy   = (phase_q == PH_FALSE) && out_space;
        fire.ctl = ctl_rdy && ctl_valid;
        fire.tru = t_rdy && t_valid;
        fire.fls = f_rdy && f_valid;
    end

    always_comb begin
        phase_d = phase_q;
        case (phase_q)
            PH_CTRL:  if (fire.ctl) phase_d = phase_after_ctrl(ctl_bit);
            PH_TRUE:  if (fire.tru) phase_d = PH_CTRL;
            PH_FALSE: if (fire.fls) phase_d = PH_CTRL;
            default:  phase_d = PH_CTRL;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_CTRL;
        else     phase_q <= phase_d;
    end

endmodule

// File: rtl/sel_src_mux.sv
module sel_src_mux
    import strm_sel_pkg::*;
#(
    parameter int W = SEL_DATA_W
) (
    input  fire_t          fire,
    input  logic [W-1:0]   t_data,
    input  logic [W-1:0]   f_data,
    output logic           load,
    output logic [W-1:0]   dout
);

    always_comb begin
        load = fire.tru || fire.fls;
        dout = fire.tru ? t_data : f_data;
    end

endmodule

// File: rtl/sel_out_stage.sv
module sel_out_stage
    import strm_sel_pkg::*;
#(
    parameter int W = SEL_DATA_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           load,
    input  logic [W-1:0]   din,
    input  logic           taken,
    output logic           held,
    output logic [W-1:0]   dout,
    output logic           space
);

    assign space = out_has_space(held, taken);

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= 1'b0;
            dout <= '0;
        end else if (load) begin
            held <= 1'b1;
            dout <= din;
        end else if (taken) begin
            held <= 1'b0;
        end
    end

endmodule

// File: rtl/strm_select.sv
module strm_select
    import strm_sel_pkg::*;
#(
    parameter int DATA_W = SEL_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_valid,
    output logic              ctl_ready,
    input  logic              ctl_data,
    input  logic              tdat_valid,
    output logic              tdat_ready,
    input  logic [DATA_W-1:0] tdat_data,
    input  logic              fdat_valid,
    output logic              fdat_ready,
    input  logic [DATA_W-1:0] fdat_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data
);

    fire_t             fire;
    logic              space;
    logic              load;
    logic [DATA_W-1:0] load_data;

    sel_fire_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ctl_valid (ctl_valid),
        .ctl_bit   (ctl_data),
        .t_valid   (tdat_valid),
        .f_valid   (fdat_valid),
        .out_space (space),
        .ctl_rdy   (ctl_ready),
        .t_rdy     (tdat_ready),
        .f_rdy     (fdat_ready),
        .fire      (fire)
    );

    sel_src_mux #(.W(DATA_W)) u_mux (
        .fire   (fire),
        .t_data (tdat_data),
        .f_data (fdat_data),
        .load   (load),
        .dout   (load_data)
    );

    sel_out_stage #(.W(DATA_W)) u_out (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .din   (load_data),
        .taken (out_ready),
        .held  (out_valid),
        .dout  (out_data),
        .space (space)
    );

endmodule

// File: rtl/strm_select_chk.sv
module strm_select_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              ctl_valid,
    input logic              ctl_ready,
    input logic              ctl_data,
    input logic              tdat_valid,
    input logic              tdat_ready,
    input logic [DATA_W-1:0] tdat_data,
    input logic              fdat_valid,
    input logic              fdat_ready,
    input logic [DATA_W-1:0] fdat_data,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data
);

    AST_ONE_READY: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ctl_ready, tdat_ready, fdat_ready})); // R5

    AST_CTRL_NO_DATA: assert property (@(posedge clk) disable iff (rst)
        ctl_ready |-> (!tdat_ready && !fdat_ready)); // R2

    AST_TRUE_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid && ctl_ready && ctl_data) |=> (!ctl_ready && !fdat_ready)); // R3

    AST_FALSE_ROUTE: assert property (@(posedge clk) disable iff (rst)
        (ctl_valid && ctl_ready && !ctl_data) |=> (!ctl_ready && !tdat_ready)); // R4

    AST_BLOCKED_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!ctl_ready && !(tdat_valid && tdat_ready) && !(fdat_valid && fdat_ready))
        |=> !ctl_ready); // R6

    AST_STALL_NO_TAKE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |-> (!tdat_ready && !fdat_ready)); // R7

    AST_STALL_STABLE: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_data))); // R9

    AST_TRUE_TO_OUT: assert property (@(posedge clk) disable iff (rst)
        (tdat_valid && tdat_ready) |=> (out_valid && out_data == $past(tdat_data) && ctl_ready)); // R10

    AST_FALSE_TO_OUT: assert property (@(posedge clk) disable iff (rst)
        (fdat_valid && fdat_ready) |=> (out_valid && out_data == $past(fdat_data) && ctl_ready)); // R10

endmodule

bind strm_select strm_select_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/strm_select_bench.sv
module strm_select_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ctl_valid = 1'b0, ctl_ready, ctl_data = 1'b0;
    logic       tdat_valid = 1'b0, tdat_ready;
    logic [7:0] tdat_data = '0;
    logic       fdat_valid = 1'b0, fdat_ready;
    logic [7:0] fdat_data = '0;
    logic       out_valid, out_ready = 1'b1;
    logic [7:0] out_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #5 clk = ~clk;

    strm_select u_strm_select (.*);

    // vector: {control bit, true data, false data, expected output}
    localparam int NV = 6;
    localparam logic [24:0] VEC [NV] = '{
        {1'b1, 8'hA5, 8'h3C, 8'hA5},
        {1'b0, 8'hA5, 8'h3C, 8'h3C},
        {1'b1, 8'h00, 8'hFF, 8'h00},
        {1'b0, 8'h00, 8'hFF, 8'hFF},
        {1'b0, 8'h12, 8'h81, 8'h81},
        {1'b1, 8'h7E, 8'h01, 8'h7E}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check("R1 out_valid", out_valid, 0);
        check("R1 ctl_ready", ctl_ready, 1);
        check("R1 data readies", {tdat_ready, fdat_ready}, 0);

        // table walk
        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            ctl_valid = 1'b1; ctl_data = VEC[i][24];
            tdat_valid = 1'b1; tdat_data = VEC[i][23:16];
            fdat_valid = 1'b1; fdat_data = VEC[i][15:8];
            #1;
            check("R2 ctrl readies", {ctl_ready, tdat_ready, fdat_ready}, 3'b100);
            @(negedge clk);
            ctl_valid = 1'b0;
            #1;
            if (VEC[i][24]) check("R3 true phase readies", {ctl_ready, tdat_ready, fdat_ready}, 3'b010);
            else            check("R4 false phase readies", {ctl_ready, tdat_ready, fdat_ready}, 3'b001);
            @(negedge clk);
            check("R10 out_valid", out_valid, 1);
            if (VEC[i][24]) check("R3 out_data", out_data, VEC[i][7:0]);
            else            check("R4 out_data", out_data, VEC[i][7:0]);
            check("R10 back to ctrl", ctl_ready, 1);
            tdat_valid = 1'b0; fdat_valid = 1'b0;
        end
        repeat (2) @(negedge clk);

        // R6 blocking, R3 unselected token kept
        ctl_valid = 1'b1; ctl_data = 1'b1;
        fdat_valid = 1'b1; fdat_data = 8'h77;
        @(negedge clk);
        ctl_valid = 1'b0;
        for (int k = 0; k < 3; k++) begin
            #1;
            check("R6 no output while blocked", out_valid, 0);
            check("R6 ctl not ready while blocked", ctl_ready, 0);
            check("R3 false stream untouched", fdat_ready, 0);
            @(negedge clk);
        end
        tdat_valid = 1'b1; tdat_data = 8'h21;
        @(negedge clk);
        check("R3 out after block", {out_valid, out_data}, {1'b1, 8'h21});
        tdat_valid = 1'b0;
        ctl_valid = 1'b1; ctl_data = 1'b0;
        @(negedge clk);
        ctl_valid = 1'b0;
        @(negedge clk);
        check("R4 kept false token delivered", {out_valid, out_data}, {1'b1, 8'h77});
        fdat_valid = 1'b0;
        repeat (2) @(negedge clk);

        // R7/R9/R8 backpressure
        out_ready = 1'b0;
        ctl_valid = 1'b1; ctl_data = 1'b0;
        fdat_valid = 1'b1; fdat_data = 8'h5A;
        @(negedge clk);
        ctl_valid = 1'b0;
        #1;
        check("R8 empty output gives space", fdat_ready, 1);
        @(negedge clk);
        fdat_valid = 1'b0;
        check("R10 stalled token present", {out_valid, out_data}, {1'b1, 8'h5A});
        ctl_valid = 1'b1; ctl_data = 1'b1;
        tdat_valid = 1'b1; tdat_data = 8'hC3;
        @(negedge clk);
        ctl_valid = 1'b0;
        #1;
        check("R7 no take under stall", {tdat_ready, fdat_ready}, 0);
        @(negedge clk);
        check("R7 no take under stall 2", tdat_ready, 0);
        check("R9 held data", {out_valid, out_data}, {1'b1, 8'h5A});
        out_ready = 1'b1;
        #1;
        check("R8 ready when output drains", tdat_ready, 1);
        @(negedge clk);
        check("R8 handoff data", {out_valid, out_data}, {1'b1, 8'hC3});
        tdat_valid = 1'b0;
        repeat (2) @(negedge clk);

        // R8 throughput
        begin
            int cnt = 0;
            ctl_valid = 1'b1; ctl_data = 1'b1;
            tdat_valid = 1'b1; tdat_data = 8'h11;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (out_valid) cnt++;
            end
            check("R8 one token per two cycles", cnt, 10);
            ctl_valid = 1'b0; tdat_valid = 1'b0;
        end
        repeat (2) @(negedge clk);

        // R1 reset mid-phase
        ctl_valid = 1'b1; ctl_data = 1'b1;
        @(negedge clk);
        ctl_valid = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R1 reset from data phase", {ctl_ready, tdat_ready, fdat_ready, out_valid}, 4'b1000);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule